// File: doc/BRIEF.md
# Fixed-Rate Dataflow Actor Firing Controller

This block schedules one actor of a fixed-rate dataflow graph. The actor has two input arcs (A and B) and one output arc (Y). Each arc is a bounded first-in first-out queue that the block holds inside itself. Producers push tokens onto A and B, and a consumer pops tokens from Y. Each arc can start out holding a set number of zero-valued delay tokens after reset.

In every cycle the controller compares the token count on each input arc with that arc's consumption rate, and the free space on Y with the production rate. When all three tests pass, the actor fires at the next clock edge. The firing removes the oldest tokens from A and B and appends a fixed number of result tokens to Y. The actor's computation is a stand-in: every produced token carries the sum of all tokens consumed by that firing. Whether the actor fires depends on token counts only, never on token values. An actor whose consumption rates are both zero is a source, and it fires whenever Y has room.

Top module: `sdf_fire_ctl`

## Requirements
- R1: After reset, arc A holds DLY_A zero tokens, arc B holds DLY_B zero tokens and arc Y holds DLY_Y zero tokens. y_valid is high exactly when DLY_Y > 0, and y_data is 0.
- R2: busy is high in a cycle exactly when, at the start of that cycle, A holds at least CONS_A tokens, B holds at least CONS_B tokens and Y has at least PROD_Y free slots. Token values and same-cycle pushes or pops do not affect it.
- R3: fire is high for exactly the one cycle after each clock edge at which busy was high. At most one firing takes place per edge.
- R4: A firing removes the CONS_A oldest tokens from A and the CONS_B oldest tokens from B.
- R5: A firing appends PROD_Y tokens to the tail of Y. Each of these tokens equals the sum, modulo 2^W, of all tokens consumed by that firing.
- R6: Each arc delivers its tokens in the order they entered it. y_data shows the oldest token in Y while y_valid is high.
- R7: a_ready and b_ready are high exactly when their arc holds fewer than DEPTH tokens. A push while ready is low is ignored, and a pop while y_valid is low is ignored.
- R8: With CONS_A = CONS_B = 0, the actor is a source: it fires on every edge at which Y has PROD_Y free slots, and each token it produces is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_push | input | 1 | Push a token onto arc A |
| a_data | input | W | Token value for arc A |
| a_ready | output | 1 | Arc A has a free slot |
| b_push | input | 1 | Push a token onto arc B |
| b_data | input | W | Token value for arc B |
| b_ready | output | 1 | Arc B has a free slot |
| y_pop | input | 1 | Pop the head token of arc Y |
| y_data | output | W | Head token of arc Y |
| y_valid | output | 1 | Arc Y is not empty |
| fire | output | 1 | One-cycle strobe after each firing |
| busy | output | 1 | Actor is enabled and fires at the next edge |

## Verification
A wrong token count shows up at once on busy and on the ready or valid flags, which all come straight from the counts. A wrong read or write pointer does not show up until the affected tokens are consumed. It then appears as a wrong sum in y_data, one firing later, which is some cycles after the faulty edge. A reference queue model in the bench tracks every arc cycle by cycle. It compares busy, the flags and y_data on each cycle, and fire on each edge, so a bad count is caught within one cycle and a bad pointer by the first pop that exposes it.

// File: rtl/sdf_fire_ctl.sv
module sdf_fire_ctl #(
  parameter int W      = 8,
  parameter int DEPTH  = 8,
  parameter int CONS_A = 2,
  parameter int CONS_B = 1,
  parameter int PROD_Y = 3,
  parameter int DLY_A  = 1,
  parameter int DLY_B  = 0,
  parameter int DLY_Y  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_push,
  input  logic [W-1:0] a_data,
  output logic         a_ready,
  input  logic         b_push,
  input  logic [W-1:0] b_data,
  output logic         b_ready,
  input  logic         y_pop,
  output logic [W-1:0] y_data,
  output logic         y_valid,
  output logic         fire,
  output logic         busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_a [DEPTH];
  logic [W-1:0]  mem_b [DEPTH];
  logic [W-1:0]  mem_y [DEPTH];
  logic [AW-1:0] rd_a, wr_a, rd_b, wr_b, rd_y, wr_y;
  logic [CW-1:0] cnt_a, cnt_b, cnt_y;
  logic          acc_a, acc_b, acc_y, ok_a, ok_b, ok_y, en, fire_q;
  logic [W-1:0]  sum;

  assign a_ready = cnt_a < CW'(DEPTH);
  assign b_ready = cnt_b < CW'(DEPTH);
  assign y_valid = cnt_y != '0;
  assign y_data  = mem_y[rd_y];
  assign acc_a   = a_push & a_ready;
  assign acc_b   = b_push & b_ready;
  assign acc_y   = y_pop & y_valid;

  generate
    if (CONS_A == 0) begin : g_src_a
      assign ok_a = 1'b1;
    end else begin : g_need_a
      assign ok_a = cnt_a >= CW'(CONS_A);
    end
    if (CONS_B == 0) begin : g_src_b
      assign ok_b = 1'b1;
    end else begin : g_need_b
      assign ok_b = cnt_b >= CW'(CONS_B);
    end
  endgenerate

  assign ok_y = (CW'(DEPTH) - cnt_y) >= CW'(PROD_Y);
  assign en   = ok_a & ok_b & ok_y;
  assign busy = en;
  assign fire = fire_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < CONS_A; i++) sum = sum + mem_a[rd_a + AW'(i)];
    for (int i = 0; i < CONS_B; i++) sum = sum + mem_b[rd_b + AW'(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_a[i] <= '0;
      rd_a  <= '0;
      wr_a  <= AW'(DLY_A);
      cnt_a <= CW'(DLY_A);
    end else begin
      if (acc_a) begin
        mem_a[wr_a] <= a_data;
        wr_a <= wr_a + 1'b1;
      end
      if (en) rd_a <= rd_a + AW'(CONS_A);
      cnt_a <= cnt_a + CW'(acc_a) - (en ? CW'(CONS_A) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_b[i] <= '0;
      rd_b  <= '0;
      wr_b  <= AW'(DLY_B);
      cnt_b <= CW'(DLY_B);
    end else begin
      if (acc_b) begin
        mem_b[wr_b] <= b_data;
        wr_b <= wr_b + 1'b1;
      end
      if (en) rd_b <= rd_b + AW'(CONS_B);
      cnt_b <= cnt_b + CW'(acc_b) - (en ? CW'(CONS_B) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_y[i] <= '0;
      rd_y   <= '0;
      wr_y   <= AW'(DLY_Y);
      cnt_y  <= CW'(DLY_Y);
      fire_q <= 1'b0;
    end else begin
      if (acc_y) rd_y <= rd_y + 1'b1;
      if (en) begin
        for (int j = 0; j < PROD_Y; j++) mem_y[wr_y + AW'(j)] <= sum;
        wr_y <= wr_y + AW'(PROD_Y);
      end
      cnt_y  <= cnt_y + (en ? CW'(PROD_Y) : '0) - CW'(acc_y);
      fire_q <= en;
    end
  end
endmodule

// File: rtl/sdf_fire_ctl_chk.sv
module sdf_fire_ctl_chk #(
  parameter int CW     = 4,
  parameter int DEPTH  = 8,
  parameter int CONS_A = 2,
  parameter int CONS_B = 1,
  parameter int PROD_Y = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] cnt_y,
  input logic          a_push,
  input logic          a_ready,
  input logic          b_push,
  input logic          b_ready,
  input logic          y_pop,
  input logic          y_valid,
  input logic          busy,
  input logic          fire
);
  assert_fire_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> fire);
  assert_no_spurious_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !fire);
  assert_consume_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_a == $past(cnt_a) + CW'($past(a_push && a_ready)) - CW'(CONS_A));
  assert_consume_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_b == $past(cnt_b) + CW'($past(b_push && b_ready)) - CW'(CONS_B));
  assert_produce_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_y == $past(cnt_y) + CW'(PROD_Y) - CW'($past(y_pop && y_valid)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= CW'(DEPTH)) && (cnt_b <= CW'(DEPTH)) && (cnt_y <= CW'(DEPTH)));
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ready |=> cnt_a <= $past(cnt_a));
endmodule

bind sdf_fire_ctl sdf_fire_ctl_chk #(
  .CW(CW), .DEPTH(DEPTH), .CONS_A(CONS_A), .CONS_B(CONS_B), .PROD_Y(PROD_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_y(cnt_y),
  .a_push(a_push), .a_ready(a_ready), .b_push(b_push), .b_ready(b_ready),
  .y_pop(y_pop), .y_valid(y_valid), .busy(busy), .fire(fire)
);

// File: tb/tb_sdf_fire_ctl.sv
module tb_sdf_fire_ctl;
  localparam int W = 8, D = 8, CA = 2, CB = 1, PY = 3, DA = 1, DB = 0, DY = 2;

  logic clk = 0, rst_n = 0;
  logic a_push = 0, b_push = 0, y_pop = 0;
  logic [W-1:0] a_data = 0, b_data = 0;
  logic a_ready, b_ready, y_valid, fire, busy;
  logic [W-1:0] y_data;

  logic s_pop = 0;
  logic s_a_ready, s_b_ready, s_y_valid, s_fire, s_busy;
  logic [W-1:0] s_y_data;

  int tests = 0, fails = 0;
  int qa[$], qb[$], qy[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sdf_fire_ctl #(.W(W), .DEPTH(D), .CONS_A(CA), .CONS_B(CB), .PROD_Y(PY),
                 .DLY_A(DA), .DLY_B(DB), .DLY_Y(DY)) dut (
    .clk(clk), .rst_n(rst_n), .a_push(a_push), .a_data(a_data), .a_ready(a_ready),
    .b_push(b_push), .b_data(b_data), .b_ready(b_ready), .y_pop(y_pop),
    .y_data(y_data), .y_valid(y_valid), .fire(fire), .busy(busy));

  sdf_fire_ctl #(.W(W), .DEPTH(D), .CONS_A(0), .CONS_B(0), .PROD_Y(1),
                 .DLY_A(0), .DLY_B(0), .DLY_Y(0)) src (
    .clk(clk), .rst_n(rst_n), .a_push(1'b0), .a_data('0), .a_ready(s_a_ready),
    .b_push(1'b0), .b_data('0), .b_ready(s_b_ready), .y_pop(s_pop),
    .y_data(s_y_data), .y_valid(s_y_valid), .fire(s_fire), .busy(s_busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit pa, input int da, input bit pb, input int db, input bit pp);
    bit en, acc_a, acc_b, acc_y;
    logic [W-1:0] s;
    a_push = pa; a_data = W'(da); b_push = pb; b_data = W'(db); y_pop = pp;
    #1;
    chk(a_ready == (qa.size() < D), "R7 a_ready", a_ready, qa.size() < D);
    chk(b_ready == (qb.size() < D), "R7 b_ready", b_ready, qb.size() < D);
    chk(y_valid == (qy.size() > 0), "R7 y_valid", y_valid, qy.size() > 0);
    if (qy.size() > 0) chk(y_data == W'(qy[0]), "R6 y_data order", y_data, qy[0]);
    en = (qa.size() >= CA) && (qb.size() >= CB) && (D - qy.size() >= PY);
    chk(busy == en, "R2 busy", busy, en);
    acc_a = pa && qa.size() < D;
    acc_b = pb && qb.size() < D;
    acc_y = pp && qy.size() > 0;
    @(posedge clk);
    if (acc_a) qa.push_back(da & 255);
    if (acc_b) qb.push_back(db & 255);
    if (acc_y) void'(qy.pop_front());
    if (en) begin
      s = 0;
      for (int i = 0; i < CA; i++) s = s + W'(qa.pop_front());
      for (int i = 0; i < CB; i++) s = s + W'(qb.pop_front());
      for (int j = 0; j < PY; j++) qy.push_back(int'(s));
    end
    @(negedge clk);
    chk(fire == en, "R3 fire strobe", fire, en);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DA; i++) qa.push_back(0);
    for (int i = 0; i < DB; i++) qb.push_back(0);
    for (int i = 0; i < DY; i++) qy.push_back(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(y_valid == (DY > 0), "R1 y_valid after reset", y_valid, DY > 0);
    chk(y_data == 0, "R1 y_data after reset", y_data, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(fire == 0, "R1 fire after reset", fire, 0);
    rst_n = 1;
    @(negedge clk);
    // R7 fill A with B empty: no firing, extra pushes dropped
    for (int k = 0; k < 10; k++) cyc(1, 10 + k, 0, 0, 0);
    chk(a_ready == 0, "R7 A full", a_ready, 0);
    // R4 R5 feed B one token at a time
    for (int k = 0; k < 6; k++) cyc(0, 0, 1, 100 + k, 1);
    // drain Y, fill B without A
    for (int k = 0; k < 12; k++) cyc(0, 0, 1, 7 * k, 1);
    // R6 sweep of input patterns driven by an LFSR
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[5], int'(lfsr[15:8]), lfsr[1] & (k[9] | lfsr[6]),
          int'(lfsr[7:0]), lfsr[2] | (k[8] & lfsr[3]));
    end
    // output stall: no pops, Y fills and blocks firing
    for (int k = 0; k < 20; k++) cyc(1, 200 + k, 1, 3 * k, 0);
    chk(busy == 0, "R2 busy low with Y full", busy, 0);
    for (int k = 0; k < 30; k++) cyc(0, 0, 0, 0, 1);

    // R8 source actor: Y was popped never, it fills one token per edge
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    qa.delete(); qb.delete(); qy.delete();
    for (int i = 0; i < DA; i++) qa.push_back(0);
    for (int i = 0; i < DY; i++) qy.push_back(0);
    for (int k = 0; k < D; k++) begin
      chk(s_busy == 1, "R8 source enabled", s_busy, 1);
      @(negedge clk);
      chk(s_fire == 1, "R8 source fires", s_fire, 1);
      chk(s_y_data == 0, "R8 source token zero", s_y_data, 0);
    end
    chk(s_busy == 0, "R8 source blocked when Y full", s_busy, 0);
    @(negedge clk);
    chk(s_fire == 0, "R8 no fire when Y full", s_fire, 0);
    s_pop = 1;
    @(negedge clk);
    s_pop = 0;
    chk(s_busy == 1, "R8 source re-enabled after pop", s_busy, 1);
    @(negedge clk);
    chk(s_fire == 1, "R8 source fires after pop", s_fire, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule